// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block is the command-side control of a synchronous DRAM. A mode-set command captures a mode word from the bank and address pins. That word fixes the burst length, the wrap order and the read latency that every later burst uses. Each accepted read or write starts a burst at the given column. The block then steps the column address through the programmed order, one column per clock.

For reads, the block produces a data-valid strobe and a data-bus enable that trail each column by the programmed CAS latency. Both strobes drop as soon as the last read word has gone out. Write bursts step the column with no added latency and never drive the bus.

After a mode-set, the block refuses commands for two clocks. The array, refresh, byte masking and row activation sit in other blocks.

Top module: `sdram_burst_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `col_valid`, `rd_valid` and `dq_oe` are low, `cmd_ready` is high and `mode_word` is zero.
- R2: `cmd_op` is encoded as 00 = mode set, 01 = read, 10 = write, 11 = burst stop. A command is accepted only when `cmd_valid` and `cmd_ready` are both high. An accepted mode set loads `{bank, addr}` into `mode_word`, which is visible on the next cycle. `mode_word` keeps its value until the next accepted mode set.
- R3: After an accepted mode set, `cmd_ready` is low for the next two cycles. Any command offered during those cycles is ignored.
- R4: The burst length is taken from mode bits [2:0]: 000 gives 1 column, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. Every other code gives 1. `col_valid` is high for exactly that many cycles, starting the cycle after the read or write is accepted.
- R5: With mode bit 3 at 0 (sequential), beat n carries the start column's bits above the burst length unchanged. Its low bits are (start + n) modulo the burst length.
- R6: With mode bit 3 at 1 (interleaved), beat n carries the start column XOR n, where n is limited to the low bits of the burst length.
- R7: A full-page burst wraps within the 256-column page. It keeps running until a burst stop, a mode set, or a new read or write is accepted.
- R8: An accepted burst stop clears `col_valid` on the next cycle.
- R9: An accepted read or write ends any burst in progress. On the next cycle `col_valid` is high and `col_out` equals the `start_col` given with that command.
- R10: The CAS latency is taken from mode bits [6:4]: 011 gives 3 clocks and every other code gives 2. `rd_valid` is high exactly the latency number of cycles after each cycle in which `col_valid` is high for a read burst. The latency is fixed when the read is accepted.
- R11: `dq_oe` follows `rd_valid`. It is low during write bursts and low once the last read word has been delivered.
- R12: An accepted mode set also ends any burst in progress. `col_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present on `cmd_op` |
| cmd_op | input | 2 | Command code (00 mode set, 01 read, 10 write, 11 burst stop) |
| addr | input | ADDR_W (11) | Address pins, which carry the mode data during a mode set |
| bank | input | BANK_W (2) | Bank pins, which carry the upper mode bits during a mode set |
| start_col | input | COL_W (8) | First column of a read or write burst |
| col_out | output | COL_W (8) | Column address of the current beat |
| col_valid | output | 1 | `col_out` holds a live burst beat |
| rd_valid | output | 1 | A read data word is due on this cycle |
| dq_oe | output | 1 | Data bus drive enable |
| cmd_ready | output | 1 | A command can be accepted on this cycle |
| mode_word | output | ADDR_W+BANK_W (13) | Stored mode word |

## Verification
Every command is sampled at a rising edge. `col_valid`, `col_out`, `mode_word` and `cmd_ready` therefore show its effect one cycle later, and each later beat moves one cycle further. `rd_valid` and `dq_oe` arrive two or three cycles after the read beat they belong to, depending on the latency latched at that read. The bench keeps a reference model and advances it just after each rising edge, using the inputs that edge sampled. It compares every output at the following falling edge, so each expectation is checked in exactly the cycle it is due.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [1:0] {
    OP_MODE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_STOP  = 2'b11
  } cmd_op_e;

  localparam int LAT_MAX  = 3;
  localparam int LAT_W    = $clog2(LAT_MAX + 1);
  localparam int LOCK_CYC = 2;
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
  parameter int ADDR_W   = 11,
  parameter int BANK_W   = 2,
  parameter int LOCK_CYC = 2,
  parameter int LAT_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BANK_W-1:0]        bank,
  output logic [ADDR_W+BANK_W-1:0] mode_q,
  output logic [2:0]               len_code,
  output logic                     interleave,
  output logic [LAT_W-1:0]         cas_lat,
  output logic                     ready_q
);
  localparam int LCW = $clog2(LOCK_CYC + 1);

  logic [LCW-1:0] lock_q, lock_d;

  always_comb begin
    if (load)             lock_d = LCW'(LOCK_CYC);
    else if (lock_q != 0) lock_d = lock_q - 1'b1;
    else                  lock_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      lock_q  <= '0;
      ready_q <= 1'b1;
    end else begin
      if (load) mode_q <= {bank, addr};
      lock_q  <= lock_d;
      ready_q <= (lock_d == 0);
    end
  end

  assign len_code   = mode_q[2:0];
  assign interleave = mode_q[3];
  assign cas_lat    = (mode_q[6:4] == 3'b011) ? LAT_W'(3) : LAT_W'(2);
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
  parameter int COL_W = 8,
  parameter int LAT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_is_rd,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic [LAT_W-1:0] lat_in,
  output logic [COL_W-1:0] col_q,
  output logic             valid_q,
  output logic             is_rd_q,
  output logic [LAT_W-1:0] lat_q
);
  logic [COL_W-1:0] base_q, cnt_q, mask_q, cnt_nx, addr_nx;
  logic             il_q, full_q, last_beat;

  function automatic logic [COL_W-1:0] span_mask(input logic [2:0] code);
    case (code)
      3'b001:  span_mask = COL_W'(1);
      3'b010:  span_mask = COL_W'(3);
      3'b011:  span_mask = COL_W'(7);
      3'b111:  span_mask = '1;
      default: span_mask = '0;
    endcase
  endfunction

  assign cnt_nx    = cnt_q + 1'b1;
  assign addr_nx   = il_q ? (base_q ^ (cnt_nx & mask_q))
                          : ((base_q & ~mask_q) | ((base_q + cnt_nx) & mask_q));
  assign last_beat = !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      il_q    <= 1'b0;
      full_q  <= 1'b0;
      col_q   <= '0;
      valid_q <= 1'b0;
      is_rd_q <= 1'b0;
      lat_q   <= LAT_W'(2);
    end else if (start) begin
      base_q  <= start_col;
      cnt_q   <= '0;
      mask_q  <= span_mask(len_code);
      full_q  <= (len_code == 3'b111);
      il_q    <= interleave;
      col_q   <= start_col;
      valid_q <= 1'b1;
      is_rd_q <= start_is_rd;
      lat_q   <= lat_in;
    end else if (stop) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (last_beat) begin
        valid_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
        col_q <= addr_nx;
      end
    end
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int LAT_MAX = 3,
  parameter int LAT_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_beat,
  input  logic [LAT_W-1:0] lat,
  output logic             rd_valid_q,
  output logic             oe_q
);
  logic [LAT_MAX-1:1] sh_q;
  logic [LAT_MAX-1:0] taps;
  logic               tap_sel;

  assign taps = {sh_q, rd_beat};

  always_comb begin
    tap_sel = taps[1];
    for (int k = 1; k <= LAT_MAX; k++) begin
      if (int'(lat) == k) tap_sel = taps[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      rd_valid_q <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      sh_q       <= taps[LAT_MAX-2:0];
      rd_valid_q <= tap_sel;
      oe_q       <= tap_sel;
    end
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  localparam int MODE_W = ADDR_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  start_col,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              rd_valid,
  output logic              dq_oe,
  output logic              cmd_ready,
  output logic [MODE_W-1:0] mode_word
);
  logic             accept, do_mode, do_start, do_stop, burst_rd;
  logic [2:0]       len_code;
  logic             interleave;
  logic [LAT_W-1:0] cas_lat, burst_lat;

  assign accept   = cmd_valid && cmd_ready;
  assign do_mode  = accept && (cmd_op == OP_MODE);
  assign do_start = accept && ((cmd_op == OP_READ) || (cmd_op == OP_WRITE));
  assign do_stop  = accept && ((cmd_op == OP_STOP) || (cmd_op == OP_MODE));

  sdram_mode_reg #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LOCK_CYC(LOCK_CYC), .LAT_W(LAT_W)
  ) u_mode (
    .clk(clk), .rst(rst), .load(do_mode), .addr(addr), .bank(bank),
    .mode_q(mode_word), .len_code(len_code), .interleave(interleave),
    .cas_lat(cas_lat), .ready_q(cmd_ready)
  );

  sdram_col_gen #(.COL_W(COL_W), .LAT_W(LAT_W)) u_col (
    .clk(clk), .rst(rst), .start(do_start),
    .start_is_rd(cmd_op == OP_READ), .stop(do_stop),
    .start_col(start_col), .len_code(len_code), .interleave(interleave),
    .lat_in(cas_lat), .col_q(col_out), .valid_q(col_valid),
    .is_rd_q(burst_rd), .lat_q(burst_lat)
  );

  sdram_rd_pipe #(.LAT_MAX(LAT_MAX), .LAT_W(LAT_W)) u_rd (
    .clk(clk), .rst(rst), .rd_beat(col_valid && burst_rd),
    .lat(burst_lat), .rd_valid_q(rd_valid), .oe_q(dq_oe)
  );
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_valid,
  input logic [1:0]               cmd_op,
  input logic [ADDR_W-1:0]        addr,
  input logic [BANK_W-1:0]        bank,
  input logic [COL_W-1:0]         start_col,
  input logic [COL_W-1:0]         col_out,
  input logic                     col_valid,
  input logic                     rd_valid,
  input logic                     dq_oe,
  input logic                     cmd_ready,
  input logic [ADDR_W+BANK_W-1:0] mode_word
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!col_valid && !rd_valid && !dq_oe && cmd_ready));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(acc && cmd_op == 2'b00) |=> $stable(mode_word));

  p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b00) |=> (mode_word == $past({bank, addr})));

  p_lockout_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b00) |=> !cmd_ready ##1 !cmd_ready);

  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b11) |=> !col_valid);

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && (cmd_op == 2'b01 || cmd_op == 2'b10))
      |=> (col_valid && col_out == $past(start_col)));

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(col_valid, 2) || $past(col_valid, 3)));

  p_mode_ends_r12: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b00) |=> !col_valid);
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .COL_W(COL_W)
) u_chk (.*);

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;
  localparam int ADDR_W = 11;
  localparam int BANK_W = 2;
  localparam int COL_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic [BANK_W-1:0] bank = '0;
  logic [COL_W-1:0]  start_col = '0;
  logic [COL_W-1:0]  col_out;
  logic              col_valid, rd_valid, dq_oe, cmd_ready;
  logic [ADDR_W+BANK_W-1:0] mode_word;

  always #4 clk = ~clk;

  sdram_burst_seq u_sdram_burst_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .addr(addr), .bank(bank), .start_col(start_col), .col_out(col_out),
    .col_valid(col_valid), .rd_valid(rd_valid), .dq_oe(dq_oe),
    .cmd_ready(cmd_ready), .mode_word(mode_word)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  string cv_tag = "R4";

  logic [12:0] m_mode;
  int          m_lock, m_cl;
  logic        m_ready, m_cv, m_isrd, m_wrap, m_full, m_rd, h1, h2;
  logic [7:0]  m_col, m_base, m_cnt, m_mask;

  function automatic logic [7:0] mask_of(input logic [2:0] c);
    case (c)
      3'b001: return 8'd1;
      3'b010: return 8'd3;
      3'b011: return 8'd7;
      3'b111: return 8'hFF;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] col_of(input logic [7:0] b, n, m, input logic il);
    if (il) return b ^ (n & m);
    return (b & ~m) | ((b + n) & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = '0; m_lock = 0; m_cl = 2; m_ready = 1'b1; m_cv = 1'b0; m_isrd = 1'b0;
    m_wrap = 1'b0; m_full = 1'b0; m_rd = 1'b0; h1 = 1'b0; h2 = 1'b0;
    m_col = '0; m_base = '0; m_cnt = '0; m_mask = '0;
  endtask

  task automatic model_step();
    logic acc, rd_n;
    if (rst) begin model_reset(); return; end
    rd_n = (m_cl == 3) ? h2 : h1;
    h2 = h1;
    h1 = m_cv && m_isrd;
    acc = cmd_valid && m_ready;
    if (m_lock > 0) m_lock--;
    if (m_cv) begin
      if (!m_full && m_cnt == m_mask) m_cv = 1'b0;
      else begin
        m_cnt = m_cnt + 8'd1;
        m_col = col_of(m_base, m_cnt, m_mask, m_wrap);
      end
    end
    if (acc) begin
      case (cmd_op)
        2'b00: begin m_mode = {bank, addr}; m_lock = 2; m_cv = 1'b0; end
        2'b01, 2'b10: begin
          m_cv = 1'b1; m_isrd = (cmd_op == 2'b01); m_base = start_col;
          m_cnt = '0; m_col = start_col; m_mask = mask_of(m_mode[2:0]);
          m_full = (m_mode[2:0] == 3'b111); m_wrap = m_mode[3];
          m_cl = (m_mode[6:4] == 3'b011) ? 3 : 2;
        end
        default: m_cv = 1'b0;
      endcase
    end
    m_ready = (m_lock == 0);
    m_rd = rd_n;
  endtask

  task automatic compare();
    chk("R2 mode_word", 32'(mode_word), 32'(m_mode));
    chk("R3 cmd_ready", 32'(cmd_ready), 32'(m_ready));
    chk({cv_tag, " col_valid"}, 32'(col_valid), 32'(m_cv));
    if (m_cv) chk(m_full ? "R7 col" : (m_wrap ? "R6 col" : "R5 col"), 32'(col_out), 32'(m_col));
    chk("R10 rd_valid", 32'(rd_valid), 32'(m_rd));
    chk("R11 dq_oe", 32'(dq_oe), 32'(m_rd));
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [10:0] a,
                      input logic [1:0] b, input logic [7:0] sc);
    @(negedge clk);
    compare();
    cmd_valid = v; cmd_op = op; addr = a; bank = b; start_col = sc;
    @(posedge clk);
    #1;
    model_step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'b00, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [10:0] ra;
    logic [2:0]  bl;
    int r;
    void'($urandom(32'd2024));
    model_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: idle state while in reset
    chk("R1 col_valid", 32'(col_valid), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 dq_oe", 32'(dq_oe), 0);
    chk("R1 cmd_ready", 32'(cmd_ready), 1);
    chk("R1 mode_word", 32'(mode_word), 0);
    rst = 1'b0;
    @(posedge clk); #1; model_step();

    // R2, R3: mode set with option bits, then a read offered in the lockout is ignored
    step(1'b1, 2'b00, {4'b1010, 3'b011, 1'b0, 3'b010}, 2'b01, 8'h00);
    step(1'b1, 2'b01, '0, '0, 8'h77);
    step(1'b1, 2'b10, '0, '0, 8'h66);
    // R5 sequential length 4 from 0x2D, latency 3
    step(1'b1, 2'b01, '0, '0, 8'h2D);
    idle(8);
    // R6 interleaved length 8, latency 2
    step(1'b1, 2'b00, {4'b0000, 3'b010, 1'b1, 3'b011}, 2'b00, 8'h00);
    idle(2);
    step(1'b1, 2'b01, '0, '0, 8'h35);
    idle(12);
    // R7 full page write across the page wrap, then R8 stop
    step(1'b1, 2'b00, {4'b0000, 3'b010, 1'b0, 3'b111}, 2'b00, 8'h00);
    idle(2);
    step(1'b1, 2'b10, '0, '0, 8'hFE);
    idle(300);
    cv_tag = "R8";
    step(1'b1, 2'b11, '0, '0, 8'h00);
    idle(4);
    // R9 new read and write cut a full-page read short
    cv_tag = "R9";
    step(1'b1, 2'b01, '0, '0, 8'h10);
    idle(2);
    step(1'b1, 2'b01, '0, '0, 8'h80);
    idle(1);
    step(1'b1, 2'b10, '0, '0, 8'h05);
    idle(3);
    // R12 mode set ends the running burst
    cv_tag = "R12";
    step(1'b1, 2'b00, {4'b0000, 3'b011, 1'b0, 3'b001}, 2'b11, 8'h00);
    idle(6);
    // R4 every length code, including reserved ones
    cv_tag = "R4";
    for (int c = 0; c < 8; c++) begin
      step(1'b1, 2'b00, {4'b0000, 3'b010, c[0], 3'(c)}, 2'b00, 8'h00);
      idle(2);
      step(1'b1, 2'b01, '0, '0, 8'(8'h3B + c));
      idle(c == 7 ? 20 : 12);
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      r = int'($urandom_range(0, 99));
      if (r < 60) step(1'b0, 2'($urandom), 11'($urandom), 2'($urandom), 8'($urandom));
      else if (r < 66) begin
        r = int'($urandom_range(0, 5));
        bl = (r == 4) ? 3'b111 : (r == 5) ? 3'($urandom) : 3'(r);
        ra = 11'($urandom);
        ra[2:0] = bl;
        step(1'b1, 2'b00, ra, 2'($urandom), 8'($urandom));
      end else if (r < 80) step(1'b1, 2'b01, 11'($urandom), 2'($urandom), 8'($urandom));
      else if (r < 94) step(1'b1, 2'b10, 11'($urandom), 2'($urandom), 8'($urandom));
      else step(1'b1, 2'b11, 11'($urandom), 2'($urandom), 8'($urandom));
    end
    idle(10);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule